// File: doc/BRIEF.md
# Seconds Counter Real-Time Clock Peripheral

This peripheral keeps a free-running 32-bit count of seconds, compares it against a programmable alarm value, and raises one interrupt line from two sticky event flags: a once-per-second tick flag and an alarm-match flag. A 32-bit scratch word is provided for software to mark that the time is valid. A plain register bus (address, write data, write strobe, combinational read data) gives access. Seconds are formed by dividing an input clock-enable pulse stream by a parameterised ratio.

Register writes are guarded by two gates, both owned by one state machine. First, writing the magic value 0xA55A to the unlock register arms a single-use unlock bit. Second, a write is accepted only while the write-ready bit reads 1. An accepted write moves the state machine from `WG_IDLE` to `WG_BUSY` (transition *accept*). It stays there for `COMMIT_CYC` cycles, which models a slow clock-domain commit, and then returns to `WG_IDLE` (transition *commit*), applying the captured value at that moment. The unlock write is taken in `WG_IDLE` without leaving it (transition *arm*).

Flags are cleared by writing 0 to their bit position and kept by writing 1.

Top module: `sec_clock_periph`

## Requirements
- R1: After reset, control reads 0x80 (only write-ready set), seconds, alarm, scratch and unlock registers read 0, and `irq_o` is 0.
- R2: Writing exactly 0x0000A55A to offset 0x3C while write-ready is 1 sets bit 31 of that register, and write-ready stays 1. Any other value written there leaves it 0.
- R3: While the unlock bit is 0, a write to any offset other than 0x3C changes no register and leaves write-ready at 1.
- R4: With the unlock bit set, a write to any offset other than 0x3C is accepted. Write-ready (control bit 7) reads 0 for exactly `COMMIT_CYC` cycles, the new value is readable once it returns to 1, and the unlock bit is clear from the first of those cycles.
- R5: Any write presented while write-ready is 0, including a magic unlock write, is ignored.
- R6: A control write with a 1 in bit 6 (tick flag) or bit 4 (alarm flag) keeps that flag. A 0 there clears it. Control bit 7 is read-only.
- R7: While control bit 0 is 1, the seconds register increments once per `TICKS_PER_SEC` pulses of `tick_en_i`, and each increment sets the tick flag (bit 6). While bit 0 is 0, it holds its value.
- R8: An increment from 0xFFFFFFFF gives 0.
- R9: While alarm enable (bit 2) is 1 and seconds equals the alarm register (offset 0x08), the alarm flag (bit 4) is set on the next cycle.
- R10: `irq_o` is 1 exactly when (bit 6 AND bit 5) OR (bit 4 AND bit 3).
- R11: Offset 0x34 is a plain read/write word. Offsets 0x04 and 0x08 hold seconds and alarm. Every other offset not listed reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en_i | input | 1 | Prescaler pulse; `TICKS_PER_SEC` pulses make one second |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench counts the exact number of cycles that write-ready stays low. A design with an off-by-one commit counter would report 3 or 5 instead of 4. It also checks that one unlock allows only one write, and that a magic write issued during a commit does not re-arm the unlock bit. A design that fails either check would let a second write through.

The counter is run across 0xFFFFFFFF to catch a saturating count. The counter is also stopped and then fed pulses, to catch a design that counts while disabled.

The bench sweeps all four combinations of the two interrupt enables against set flags, and three keep/clear patterns of the flag bits, to catch inverted clear polarity. It also sweeps every unmapped word offset, to catch aliased decoding.

// File: rtl/sec_clock_pkg.sv
package sec_clock_pkg;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] OFF_CTRL  = 8'h00;
    localparam logic [ADDR_W-1:0] OFF_SECS  = 8'h04;
    localparam logic [ADDR_W-1:0] OFF_ALARM = 8'h08;
    localparam logic [ADDR_W-1:0] OFF_SCR   = 8'h34;
    localparam logic [ADDR_W-1:0] OFF_UNLK  = 8'h3C;

    localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h0000_A55A;

    // control bit positions
    localparam int CB_RUN   = 0;
    localparam int CB_AEN   = 2;
    localparam int CB_AIE   = 3;
    localparam int CB_AFLG  = 4;
    localparam int CB_TIE   = 5;
    localparam int CB_TFLG  = 6;
    localparam int CB_READY = 7;

    typedef enum logic [0:0] {
        WG_IDLE = 1'b0,
        WG_BUSY = 1'b1
    } wg_state_t;

    typedef struct packed {
        logic run;
        logic alarm_en;
        logic alarm_ie;
        logic alarm_flag;
        logic tick_ie;
        logic tick_flag;
    } ctrl_t;
endpackage

// File: rtl/sec_div.sv
module sec_div #(
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic tick_i,
    output logic sec_o
);
    localparam int CW = (TICKS_PER_SEC > 1) ? $clog2(TICKS_PER_SEC) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS_PER_SEC - 1);

    logic [CW-1:0] cnt_q;

    assign sec_o = run_i && tick_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    // R7: the prescale count never leaves its range
    p_div_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> (cnt_q <= LAST));
endmodule

// File: rtl/wr_gate.sv
module wr_gate
    import sec_clock_pkg::*;
#(
    parameter int COMMIT_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              ready_o,
    output logic              unlocked_o,
    output logic              commit_o,
    output logic [ADDR_W-1:0] commit_addr_o,
    output logic [DATA_W-1:0] commit_data_o
);
    localparam int CNT_W = $clog2(COMMIT_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(COMMIT_CYC - 1);

    wg_state_t         state_q, state_d;
    logic [CNT_W-1:0]  cnt_q;
    logic              unlock_q;
    logic [ADDR_W-1:0] lat_addr_q;
    logic [DATA_W-1:0] lat_data_q;
    logic              arm_hit, accept_hit, done;

    assign arm_hit    = bus_we && (state_q == WG_IDLE) &&
                        (bus_addr == OFF_UNLK) && (bus_wdata == UNLOCK_KEY);
    assign accept_hit = bus_we && (state_q == WG_IDLE) && unlock_q &&
                        (bus_addr != OFF_UNLK);
    assign done       = (state_q == WG_BUSY) && (cnt_q == '0);

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WG_IDLE: if (accept_hit) state_d = WG_BUSY;
            WG_BUSY: if (done)       state_d = WG_IDLE;
            default: state_d = WG_IDLE;
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= WG_IDLE;
            cnt_q      <= '0;
            unlock_q   <= 1'b0;
            lat_addr_q <= '0;
            lat_data_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept_hit) begin
                cnt_q      <= LOAD;
                lat_addr_q <= bus_addr;
                lat_data_q <= bus_wdata;
                unlock_q   <= 1'b0;
            end else begin
                if (arm_hit) unlock_q <= 1'b1;
                if ((state_q == WG_BUSY) && (cnt_q != '0)) cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    // output process
    always_comb begin
        ready_o       = (state_q == WG_IDLE);
        unlocked_o    = unlock_q;
        commit_o      = done;
        commit_addr_o = lat_addr_q;
        commit_data_o = lat_data_q;
    end

    p_accept_drops_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        accept_hit |=> (!ready_o && !unlocked_o));
    p_locked_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && ready_o && !unlocked_o && bus_addr != OFF_UNLK) |=> ready_o);
    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready_o && !commit_o) |=> ($stable(commit_data_o) && !ready_o));
    p_arm_keeps_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        arm_hit |=> (ready_o && unlocked_o));
endmodule

// File: rtl/sec_clock_periph.sv
module sec_clock_periph
    import sec_clock_pkg::*;
#(
    parameter int COMMIT_CYC    = 4,
    parameter int TICKS_PER_SEC = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en_i,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_o
);
    logic              ready, unlocked, commit;
    logic [ADDR_W-1:0] c_addr;
    logic [DATA_W-1:0] c_data;
    logic              sec_pulse;
    logic              wr_ctrl, wr_secs, wr_alarm, wr_scr;

    ctrl_t             ctrl_q;
    logic [DATA_W-1:0] secs_q, alarm_q, scr_q;

    wr_gate #(.COMMIT_CYC(COMMIT_CYC)) u_gate (
        .clk           (clk),
        .rst_n         (rst_n),
        .bus_we        (bus_we),
        .bus_addr      (bus_addr),
        .bus_wdata     (bus_wdata),
        .ready_o       (ready),
        .unlocked_o    (unlocked),
        .commit_o      (commit),
        .commit_addr_o (c_addr),
        .commit_data_o (c_data)
    );

    sec_div #(.TICKS_PER_SEC(TICKS_PER_SEC)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (ctrl_q.run),
        .tick_i (tick_en_i),
        .sec_o  (sec_pulse)
    );

    assign wr_ctrl  = commit && (c_addr == OFF_CTRL);
    assign wr_secs  = commit && (c_addr == OFF_SECS);
    assign wr_alarm = commit && (c_addr == OFF_ALARM);
    assign wr_scr   = commit && (c_addr == OFF_SCR);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            secs_q  <= '0;
            alarm_q <= '0;
            scr_q   <= '0;
        end else begin
            if (wr_secs)        secs_q <= c_data;
            else if (sec_pulse) secs_q <= secs_q + 32'd1;

            if (wr_alarm) alarm_q <= c_data;
            if (wr_scr)   scr_q   <= c_data;

            if (wr_ctrl) begin
                ctrl_q.run      <= c_data[CB_RUN];
                ctrl_q.alarm_en <= c_data[CB_AEN];
                ctrl_q.alarm_ie <= c_data[CB_AIE];
                ctrl_q.tick_ie  <= c_data[CB_TIE];
            end

            // sticky flags: a set event wins over a clear in the same cycle
            if (sec_pulse)    ctrl_q.tick_flag <= 1'b1;
            else if (wr_ctrl) ctrl_q.tick_flag <= ctrl_q.tick_flag & c_data[CB_TFLG];

            if (ctrl_q.alarm_en && (secs_q == alarm_q)) ctrl_q.alarm_flag <= 1'b1;
            else if (wr_ctrl) ctrl_q.alarm_flag <= ctrl_q.alarm_flag & c_data[CB_AFLG];
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFF_CTRL: begin
                bus_rdata[CB_READY] = ready;
                bus_rdata[CB_TFLG]  = ctrl_q.tick_flag;
                bus_rdata[CB_TIE]   = ctrl_q.tick_ie;
                bus_rdata[CB_AFLG]  = ctrl_q.alarm_flag;
                bus_rdata[CB_AIE]   = ctrl_q.alarm_ie;
                bus_rdata[CB_AEN]   = ctrl_q.alarm_en;
                bus_rdata[CB_RUN]   = ctrl_q.run;
            end
            OFF_SECS:  bus_rdata = secs_q;
            OFF_ALARM: bus_rdata = alarm_q;
            OFF_SCR:   bus_rdata = scr_q;
            OFF_UNLK:  bus_rdata[DATA_W-1] = unlocked;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq_o = (ctrl_q.tick_flag && ctrl_q.tick_ie) ||
                   (ctrl_q.alarm_flag && ctrl_q.alarm_ie);

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !wr_secs) |=> (secs_q == $past(secs_q) + 32'd1));
    p_wrap_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_pulse && !wr_secs && secs_q == 32'hFFFF_FFFF) |=> (secs_q == 32'd0));
    p_alarm_sets_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.alarm_en && secs_q == alarm_q) |=> ctrl_q.alarm_flag);
    p_flag_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.tick_flag && !wr_ctrl) |=> ctrl_q.tick_flag);
    p_stopped_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_secs) |=> $stable(secs_q));
endmodule

// File: tb/sec_clock_periph_tb.sv
module sec_clock_periph_tb;
    localparam int CC = 4;
    localparam int TK = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en_i = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        irq_o;

    int n_chk = 0;
    int n_fail = 0;

    sec_clock_periph #(.COMMIT_CYC(CC), .TICKS_PER_SEC(TK)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_en_i(tick_en_i),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
        .bus_rdata(bus_rdata), .irq_o(irq_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic wait_ready(output int n);
        n = 0;
        #1;
        while (!bus_rdata[7] && n < 100) begin
            n++;
            @(negedge clk);
            #1;
        end
    endtask

    task automatic uwrite(input logic [7:0] a, input logic [31:0] d);
        int n;
        wr(8'h3C, 32'h0000_A55A);
        wr(a, d);
        wait_ready(n);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick_en_i = 1'b1;
            @(negedge clk); tick_en_i = 1'b0;
        end
    endtask

    task automatic finish_up;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        finish_up();
    end

    initial begin
        logic [31:0] v;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(8'h00, v); chk(v == 32'h80, "R1 ctrl", v, 32'h80);
        rd(8'h04, v); chk(v == 0, "R1 secs", v, 0);
        rd(8'h08, v); chk(v == 0, "R1 alarm", v, 0);
        rd(8'h34, v); chk(v == 0, "R1 scratch", v, 0);
        rd(8'h3C, v); chk(v == 0, "R1 unlock", v, 0);
        chk(irq_o == 1'b0, "R1 irq", {31'd0, irq_o}, 0);

        // R3 locked write ignored
        wr(8'h34, 32'h1234);
        #1 chk(bus_rdata[7] == 1'b1, "R3 ready stays", bus_rdata, 32'h80);
        repeat (CC + 1) @(negedge clk);
        rd(8'h34, v); chk(v == 0, "R3 scratch unchanged", v, 0);

        // R2 unlock key
        wr(8'h3C, 32'h1234);
        rd(8'h3C, v); chk(v == 0, "R2 wrong key", v, 0);
        wr(8'h3C, 32'h0000_A55A);
        #1 chk(bus_rdata[7] == 1'b1, "R2 ready after arm", bus_rdata, 32'h80);
        rd(8'h3C, v); chk(v == 32'h8000_0000, "R2 armed", v, 32'h8000_0000);

        // R4 commit length, value, unlock consumed
        wr(8'h34, 32'hDEAD_BEEF);
        wait_ready(n);
        chk(n == CC, "R4 busy cycles", n, CC);
        rd(8'h34, v); chk(v == 32'hDEAD_BEEF, "R11 scratch rw", v, 32'hDEAD_BEEF);
        rd(8'h3C, v); chk(v == 0, "R4 unlock consumed", v, 0);
        wr(8'h34, 32'h5);
        repeat (CC + 1) @(negedge clk);
        rd(8'h34, v); chk(v == 32'hDEAD_BEEF, "R4 single use", v, 32'hDEAD_BEEF);

        // R5 writes during busy ignored
        wr(8'h3C, 32'h0000_A55A);
        wr(8'h34, 32'h11);
        wr(8'h3C, 32'h0000_A55A);
        wait_ready(n);
        rd(8'h3C, v); chk(v == 0, "R5 arm while busy", v, 0);
        rd(8'h34, v); chk(v == 32'h11, "R5 first write kept", v, 32'h11);

        // R11 unmapped sweep
        for (int a = 0; a < 256; a += 4) begin
            if (a != 8'h00 && a != 8'h04 && a != 8'h08 && a != 8'h34 && a != 8'h3C) begin
                rd(8'(a), v); chk(v == 0, "R11 unmapped", v, 0);
            end
        end

        // R7 counting
        uwrite(8'h04, 32'd10);
        uwrite(8'h00, 32'h01);
        for (int k = 1; k <= 3; k++) begin
            ticks(TK - 1);
            rd(8'h04, v); chk(v == 32'(10 + k - 1), "R7 partial", v, 32'(10 + k - 1));
            ticks(1);
            rd(8'h04, v); chk(v == 32'(10 + k), "R7 step", v, 32'(10 + k));
        end
        rd(8'h00, v); chk(v[6] == 1'b1, "R7 tick flag", v, 32'h41);

        // R7 stopped, R6 keep flag
        uwrite(8'h00, 32'h50);
        ticks(2 * TK);
        rd(8'h04, v); chk(v == 32'd13, "R7 held", v, 32'd13);
        rd(8'h00, v); chk(v == 32'hC0, "R6 kept by 1", v, 32'hC0);
        uwrite(8'h00, 32'h10);
        rd(8'h00, v); chk(v == 32'h80, "R6 cleared by 0", v, 32'h80);

        // R8 wrap
        uwrite(8'h04, 32'hFFFF_FFFF);
        uwrite(8'h00, 32'h01);
        ticks(TK);
        rd(8'h04, v); chk(v == 0, "R8 wrap", v, 0);

        // R9 alarm
        uwrite(8'h00, 32'h00);
        uwrite(8'h08, 32'd5);
        uwrite(8'h04, 32'd3);
        uwrite(8'h00, 32'h05);
        ticks(TK);
        rd(8'h00, v); chk(v[4] == 1'b0, "R9 no early alarm", v, 32'hC5);
        ticks(TK);
        rd(8'h00, v); chk(v[4] == 1'b1, "R9 alarm flag", v, 32'hD5);
        chk(irq_o == 1'b0, "R10 masked", {31'd0, irq_o}, 0);

        // R10 enable sweep with both flags set
        for (int c = 0; c < 4; c++) begin
            uwrite(8'h00, 32'h50 | ((c & 1) ? 32'h20 : 0) | ((c & 2) ? 32'h08 : 0));
            #1 chk(irq_o == (c != 0), "R10 irq combo", {31'd0, irq_o}, (c != 0));
        end

        // R6 keep/clear patterns
        uwrite(8'h00, 32'h50);
        rd(8'h00, v); chk(v[6] && v[4], "R6 keep both", v, 32'hD0);
        uwrite(8'h00, 32'h48);
        rd(8'h00, v); chk(v == 32'hC8, "R6 clear alarm only", v, 32'hC8);
        chk(irq_o == 1'b0, "R10 alarm cleared", {31'd0, irq_o}, 0);
        uwrite(8'h00, 32'h80);
        rd(8'h00, v); chk(v == 32'h80, "R6 clear both, ready ro", v, 32'h80);

        finish_up();
    end
endmodule